// File: doc/BRIEF.md
# Character LCD Text Writer with Busy-Flag Polling

This block drives a two-row, twenty-column character display controller through a separate bus engine. It never waits a fixed time after an instruction. Before each instruction or character byte it reads the controller's status. It issues the byte only once the busy flag, bit 7 of that status, reads 0. The bus engine is a request/response port: the block holds a request with register select, read/write and write data until the engine returns a one-cycle acknowledge. On a read, the status byte comes back with that acknowledge.

Out of reset the block first waits a parameterised power-up interval, because the busy flag cannot be trusted that early. It then brings the display up with four instructions: function set, display on, clear, and entry mode. After that it accepts host commands over a valid/ready port. A command can place a character at the cursor, move the cursor to a row and column, or clear the screen. Rows and columns are translated into the display's split address space, where row 1 starts at 0x40.

A move to a position that does not exist is rejected with a one-cycle error pulse and causes no bus traffic. So does the reserved opcode. If the busy flag stays set longer than a parameterised limit, the block enters a sticky fault state and stops.

Top module: `lcd_text_writer`

## Requirements
- R1: After reset the block keeps `bus_req`, `cmd_ready`, `err_pulse` and `fault` at 0, and it raises no bus request until at least PWRUP_CYCLES clock cycles have passed since reset release.
- R2: The start-up sequence is four instruction writes with RS=0, in this order: 0x38 (8-bit bus, two lines, 5x8 font), 0x0C (display on, cursor off, blink off), 0x01 (clear), 0x06 (increment, no shift). After the fourth write, `cmd_ready` rises.
- R3: Each write on the bus (RS=x, R/W=0) comes directly after a status read (RS=0, R/W=1) whose returned bit 7 was 0. A status read that returns bit 7 = 1 is followed by another status read.
- R4: Opcode 0 (character) produces one data write with RS=1 and the byte equal to `cmd_char`.
- R5: Opcode 1 (move) produces one instruction write with RS=0 and byte 0x80 | (row*0x40 + col), for row 0..1 and col 0..19.
- R6: Opcode 2 (clear) produces one instruction write with RS=0 and byte 0x01.
- R7: A move with col >= 20 or row >= 2, or any command with opcode 3, gives `err_pulse` = 1 for exactly the cycle after acceptance. It causes no bus request, and `cmd_ready` stays 1.
- R8: If status reads keep returning bit 7 = 1 after POLL_LIMIT cycles of polling for one byte, `fault` goes to 1. It then stays at 1, with `bus_req` and `cmd_ready` at 0, until reset.
- R9: Once raised, `bus_req` stays high with `bus_rs`, `bus_rw` and `bus_wdata` unchanged until the cycle in which `bus_ack` is 1.
- R10: `cmd_ready` is 0 from the cycle after an accepted valid command until that command's write has been acknowledged, and no bus request is made while `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 character, 1 move, 2 clear, 3 reserved |
| cmd_char | input | 8 | Character code for opcode 0 |
| cmd_row | input | ROW_W (2) | Target row for opcode 1 |
| cmd_col | input | COL_W (5) | Target column for opcode 1 |
| err_pulse | output | 1 | One-cycle pulse on a rejected command |
| fault | output | 1 | Sticky busy-flag timeout |
| bus_req | output | 1 | Bus engine request |
| bus_rs | output | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | One-cycle acknowledge from the bus engine |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |

## Verification
The bench builds the block with PWRUP_CYCLES = 50 and POLL_LIMIT = 40 in place of the multi-millisecond defaults. With these values the whole power-up wait and the timeout-to-fault path fit in a few hundred cycles, next to normal traffic. The bench's bus model returns a configurable number of busy status reads before each clear one, and that number is kept below the limit for normal traffic. This exercises the repeated-poll path without faulting. A final phase holds the busy flag high to reach the sticky fault.

// File: rtl/lcd_wr_pkg.sv
`timescale 1ns/1ps
package lcd_wr_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_POLL  = 3'd1,
    ST_ISSUE = 3'd2,
    ST_IDLE  = 3'd3,
    ST_FAULT = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_CHAR  = 2'd0,
    OP_MOVE  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_RSVD  = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic       rs;
    logic [7:0] code;
  } bus_word_t;

  // instruction fields
  localparam logic BUS_8BIT   = 1'b1;
  localparam logic TWO_LINES  = 1'b1;
  localparam logic FONT_5X8   = 1'b0;
  localparam logic DISP_ON    = 1'b1;
  localparam logic CURSOR_ON  = 1'b0;
  localparam logic BLINK_ON   = 1'b0;
  localparam logic ADDR_INC   = 1'b1;
  localparam logic SHIFT_DISP = 1'b0;

  localparam logic [7:0] INS_FUNC   = {3'b001, BUS_8BIT, TWO_LINES, FONT_5X8, 2'b00};
  localparam logic [7:0] INS_DISP   = {5'b00001, DISP_ON, CURSOR_ON, BLINK_ON};
  localparam logic [7:0] INS_CLEAR  = 8'h01;
  localparam logic [7:0] INS_ENTRY  = {6'b000001, ADDR_INC, SHIFT_DISP};
  localparam logic [7:0] INS_SETPOS = 8'h80;

  localparam int INIT_STEPS = 4;

  function automatic logic [7:0] init_byte(input logic [1:0] idx);
    logic [7:0] b;
    case (idx)
      2'd0:    b = INS_FUNC;
      2'd1:    b = INS_DISP;
      2'd2:    b = INS_CLEAR;
      default: b = INS_ENTRY;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lcd_wr_addr_map.sv
`timescale 1ns/1ps
module lcd_wr_addr_map #(
  parameter int ROWS       = 2,
  parameter int COLS       = 20,
  parameter int ROW_W      = 2,
  parameter int COL_W      = 5,
  parameter int ROW_STRIDE = 64,
  parameter int ADDR_W     = 7
) (
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] addr,
  output logic              in_range
);

  localparam int SUM_W = ROW_W + COL_W + $clog2(ROW_STRIDE) + 1;

  logic [SUM_W-1:0] row_base;
  logic [SUM_W-1:0] sum;

  always_comb begin
    in_range = (int'(row) < ROWS) && (int'(col) < COLS);
    row_base = SUM_W'(row) * SUM_W'(ROW_STRIDE);
    sum      = row_base + SUM_W'(col);
    addr     = sum[ADDR_W-1:0];
  end

endmodule

// File: rtl/lcd_wr_decode.sv
`timescale 1ns/1ps
module lcd_wr_decode
  import lcd_wr_pkg::*;
#(
  parameter int ROWS  = 2,
  parameter int COLS  = 20,
  parameter int ROW_W = 2,
  parameter int COL_W = 5
) (
  input  logic [1:0]       op,
  input  logic [7:0]       char_code,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output bus_word_t        word,
  output logic             ok
);

  localparam int ADDR_W = 7;

  logic [ADDR_W-1:0] ddram_addr;
  logic              pos_ok;

  lcd_wr_addr_map #(
    .ROWS      (ROWS),
    .COLS      (COLS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .ROW_STRIDE(64),
    .ADDR_W    (ADDR_W)
  ) u_map (
    .row     (row),
    .col     (col),
    .addr    (ddram_addr),
    .in_range(pos_ok)
  );

  always_comb begin
    word = '0;
    ok   = 1'b0;
    case (cmd_op_e'(op))
      OP_CHAR: begin
        word = '{rs: 1'b1, code: char_code};
        ok   = 1'b1;
      end
      OP_MOVE: begin
        word = '{rs: 1'b0, code: INS_SETPOS | {1'b0, ddram_addr}};
        ok   = pos_ok;
      end
      OP_CLEAR: begin
        word = '{rs: 1'b0, code: INS_CLEAR};
        ok   = 1'b1;
      end
      default: begin
        word = '0;
        ok   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lcd_wr_timer.sv
`timescale 1ns/1ps
module lcd_wr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || (en && (cnt != {CNT_W{1'b1}}));
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/lcd_wr_seq.sv
`timescale 1ns/1ps
module lcd_wr_seq
  import lcd_wr_pkg::*;
#(
  parameter int PWRUP_CYCLES = 8000000,
  parameter int POLL_LIMIT   = 4096,
  parameter int CNT_W        = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_ok,
  input  bus_word_t        cmd_word,
  output logic             cmd_ready,
  output logic             err_pulse,
  output logic             fault,
  input  logic [CNT_W-1:0] cnt,
  output logic             tmr_clr,
  output logic             tmr_en,
  output logic             bus_req,
  output logic             bus_rs,
  output logic             bus_rw,
  output logic [7:0]       bus_wdata,
  input  logic             bus_ack,
  input  logic             bus_busy
);

  localparam logic [CNT_W-1:0] PWR_LAST = CNT_W'(PWRUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] POLL_MAX = CNT_W'(POLL_LIMIT);

  seq_state_e state_q, state_d;
  logic [1:0] step_q, step_d;
  logic       init_q, init_d;
  bus_word_t  pend_q, pend_d;
  logic       pend_en;
  logic       err_q, err_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    init_d  = init_q;
    pend_d  = pend_q;
    pend_en = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_PWRUP: begin
        if (cnt >= PWR_LAST) begin
          state_d = ST_POLL;
          init_d  = 1'b1;
          step_d  = 2'd0;
          pend_d  = '{rs: 1'b0, code: init_byte(2'd0)};
          pend_en = 1'b1;
        end
      end
      ST_POLL: begin
        if (bus_ack) begin
          if (!bus_busy)             state_d = ST_ISSUE;
          else if (cnt >= POLL_MAX)  state_d = ST_FAULT;
        end
      end
      ST_ISSUE: begin
        if (bus_ack) begin
          if (init_q && (int'(step_q) != INIT_STEPS - 1)) begin
            state_d = ST_POLL;
            step_d  = step_q + 2'd1;
            pend_d  = '{rs: 1'b0, code: init_byte(step_q + 2'd1)};
            pend_en = 1'b1;
          end else begin
            state_d = ST_IDLE;
            init_d  = 1'b0;
          end
        end
      end
      ST_IDLE: begin
        if (cmd_valid) begin
          if (cmd_ok) begin
            state_d = ST_POLL;
            pend_d  = cmd_word;
            pend_en = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      default: state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      step_q  <= 2'd0;
      init_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      init_q  <= init_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_comb begin
    tmr_en    = (state_q == ST_PWRUP) || (state_q == ST_POLL);
    tmr_clr   = !tmr_en || (state_q == ST_PWRUP && state_d != ST_PWRUP);
    cmd_ready = (state_q == ST_IDLE);
    err_pulse = err_q;
    fault     = (state_q == ST_FAULT);
    bus_req   = (state_q == ST_POLL) || (state_q == ST_ISSUE);
    bus_rw    = (state_q == ST_POLL);
    bus_rs    = (state_q == ST_ISSUE) ? pend_q.rs : 1'b0;
    bus_wdata = (state_q == ST_ISSUE) ? pend_q.code : 8'h00;
  end

  // ---------------- assertions ----------------
  logic bf_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bf_ok_q <= 1'b0;
    end else if (bus_ack) begin
      bf_ok_q <= bus_rw && !bus_busy;
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_rs) && $stable(bus_rw) && $stable(bus_wdata));

  assert_write_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rw |-> bf_ok_q);

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault && !bus_req && !cmd_ready);

  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(cmd_valid) && !bus_req && cmd_ready);

  assert_ready_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_req);

endmodule

// File: rtl/lcd_text_writer.sv
`timescale 1ns/1ps
module lcd_text_writer
  import lcd_wr_pkg::*;
#(
  parameter int PWRUP_CYCLES = 8000000,
  parameter int POLL_LIMIT   = 4096,
  parameter int ROWS         = 2,
  parameter int COLS         = 20,
  parameter int ROW_W        = 2,
  parameter int COL_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_char,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [COL_W-1:0] cmd_col,
  output logic             err_pulse,
  output logic             fault,
  output logic             bus_req,
  output logic             bus_rs,
  output logic             bus_rw,
  output logic [7:0]       bus_wdata,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata
);

  localparam int MAX_CNT = (PWRUP_CYCLES > POLL_LIMIT) ? PWRUP_CYCLES : POLL_LIMIT;
  localparam int CNT_W   = $clog2(MAX_CNT + 2);

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  bus_word_t        dec_word;
  logic             dec_ok;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_clr;
  logic             tmr_en;
  logic             unused_status_bits;

  assign unused_status_bits = ^bus_rdata[6:0];

  lcd_wr_decode #(
    .ROWS (ROWS),
    .COLS (COLS),
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) u_decode (
    .op       (cmd_op),
    .char_code(cmd_char),
    .row      (cmd_row),
    .col      (cmd_col),
    .word     (dec_word),
    .ok       (dec_ok)
  );

  lcd_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (tmr_clr),
    .en   (tmr_en),
    .cnt  (tmr_cnt)
  );

  lcd_wr_seq #(
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .POLL_LIMIT  (POLL_LIMIT),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_valid(cmd_valid),
    .cmd_ok   (dec_ok),
    .cmd_word (dec_word),
    .cmd_ready(cmd_ready),
    .err_pulse(err_pulse),
    .fault    (fault),
    .cnt      (tmr_cnt),
    .tmr_clr  (tmr_clr),
    .tmr_en   (tmr_en),
    .bus_req  (bus_req),
    .bus_rs   (bus_rs),
    .bus_rw   (bus_rw),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .bus_busy (bus_rdata[7])
  );

endmodule

// File: tb/lcd_text_writer_tb.sv
`timescale 1ns/1ps
module lcd_text_writer_tb;

  localparam int PWR  = 50;
  localparam int PLIM = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [1:0] cmd_op;
  logic [7:0] cmd_char;
  logic [1:0] cmd_row;
  logic [4:0] cmd_col;
  logic       err_pulse, fault;
  logic       bus_req, bus_rs, bus_rw;
  logic [7:0] bus_wdata;
  logic       bus_ack;
  logic [7:0] bus_rdata;

  always #2.5 clk = ~clk;

  lcd_text_writer #(.PWRUP_CYCLES(PWR), .POLL_LIMIT(PLIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_char(cmd_char), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .err_pulse(err_pulse), .fault(fault), .bus_req(bus_req), .bus_rs(bus_rs),
    .bus_rw(bus_rw), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int failures = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  int  n_wr = 0, n_rd = 0, n_err = 0;
  int  busy_left = 0, busy_reload = 2;
  bit  busy_forever = 0;
  bit  last_rd_clear = 0;
  bit  hold = 0;
  logic [9:0] held;
  int  cyc_since_rst = 0;
  int  first_req = -1;
  bit  finished = 0;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bus engine model and scoreboard monitor
  initial begin
    bus_ack = 1'b0;
    bus_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        bus_ack = 1'b0; hold = 0; cyc_since_rst = 0; first_req = -1;
      end else begin
        cyc_since_rst++;
        if (err_pulse) n_err++;
        if (bus_req && first_req < 0) first_req = cyc_since_rst;
        if (bus_ack) begin
          bus_ack = 1'b0;
        end else if (bus_req && !hold) begin
          hold = 1;
          held = {bus_rs, bus_rw, bus_wdata};
        end else if (bus_req && hold) begin
          hold = 0;
          if ({bus_rs, bus_rw, bus_wdata} != held)
            chk(0, "R9", int'({bus_rs, bus_rw, bus_wdata}), int'(held));
          bus_ack = 1'b1;
          if (bus_rw) begin
            n_rd++;
            chk(bus_rs == 1'b0, "R3", bus_rs, 0);
            bus_rdata = (busy_forever || busy_left > 0) ? 8'h80 : 8'h00;
            if (busy_left > 0) busy_left--;
            last_rd_clear = !bus_rdata[7];
          end else begin
            n_wr++;
            chk(last_rd_clear, "R3", 0, 1);
            last_rd_clear = 0;
            busy_left = busy_reload;
            if (exp_q.size() == 0) begin
              chk(0, "R4", int'({bus_rs, bus_wdata}), 0);
            end else begin
              logic [8:0] e;
              string t;
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              chk({bus_rs, bus_wdata} == e, t, int'({bus_rs, bus_wdata}), int'(e));
            end
          end
        end else if (!bus_req && hold) begin
          chk(0, "R9", 0, 1);
          hold = 0;
        end
      end
    end
  end

  task automatic expect_wr(input logic rs, input logic [7:0] b, input string t);
    exp_q.push_back({rs, b});
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] ch,
                      input logic [1:0] row, input logic [4:0] col,
                      output logic ready_after, output logic err_after);
    int w = 0;
    @(negedge clk);
    while (!cmd_ready && w < 2000) begin @(negedge clk); w++; end
    cmd_op = op; cmd_char = ch; cmd_row = row; cmd_col = col;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    ready_after = cmd_ready;
    err_after = err_pulse;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!(cmd_ready && exp_q.size() == 0) && w < 2000) begin @(negedge clk); w++; end
  endtask

  task automatic reject(input logic [1:0] op, input logic [1:0] row, input logic [4:0] col);
    int wr0, rd0, er0;
    logic r, e;
    wr0 = n_wr; rd0 = n_rd; er0 = n_err;
    send(op, 8'h41, row, col, r, e);
    chk(e == 1'b1, "R7", e, 1);
    chk(r == 1'b1, "R7", r, 1);
    repeat (6) @(negedge clk);
    chk(n_wr == wr0 && n_rd == rd0, "R7", n_wr + n_rd, wr0 + rd0);
    chk(n_err == er0 + 1, "R7", n_err - er0, 1);
    chk(cmd_ready == 1'b1, "R7", cmd_ready, 1);
  endtask

  initial begin
    logic r, e;
    int wr0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_char = 8'h00;
    cmd_row = 2'd0; cmd_col = 5'd0;
    repeat (3) @(negedge clk);
    chk(bus_req == 0 && cmd_ready == 0 && fault == 0 && err_pulse == 0, "R1",
        {bus_req, cmd_ready, fault, err_pulse}, 0);

    expect_wr(1'b0, 8'h38, "R2");
    expect_wr(1'b0, 8'h0C, "R2");
    expect_wr(1'b0, 8'h01, "R2");
    expect_wr(1'b0, 8'h06, "R2");
    rst_n = 1'b1;
    wait_done();
    chk(first_req >= PWR, "R1", first_req, PWR);
    chk(cmd_ready == 1'b1, "R2", cmd_ready, 1);
    chk(n_wr == 4, "R2", n_wr, 4);
    // first byte: one clear read; next three: two busy reads then one clear
    chk(n_rd == 10, "R3", n_rd, 10);
    chk(fault == 1'b0, "R8", fault, 0);

    expect_wr(1'b1, 8'h48, "R4");
    send(2'd0, 8'h48, 2'd3, 5'd31, r, e);
    chk(r == 1'b0, "R10", r, 0);
    wait_done();
    busy_reload = 0;
    expect_wr(1'b1, 8'h69, "R4");
    send(2'd0, 8'h69, 2'd0, 5'd0, r, e);
    wait_done();
    busy_reload = 3;

    expect_wr(1'b0, 8'h85, "R5");
    send(2'd1, 8'h00, 2'd0, 5'd5, r, e);
    chk(r == 1'b0, "R10", r, 0);
    wait_done();
    expect_wr(1'b0, 8'hD3, "R5");
    send(2'd1, 8'h00, 2'd1, 5'd19, r, e);
    wait_done();
    expect_wr(1'b0, 8'hC0, "R5");
    send(2'd1, 8'h00, 2'd1, 5'd0, r, e);
    wait_done();
    expect_wr(1'b0, 8'h93, "R5");
    send(2'd1, 8'h00, 2'd0, 5'd19, r, e);
    wait_done();

    expect_wr(1'b0, 8'h01, "R6");
    send(2'd2, 8'hFF, 2'd1, 5'd7, r, e);
    wait_done();

    reject(2'd1, 2'd0, 5'd20);
    reject(2'd1, 2'd2, 5'd0);
    reject(2'd1, 2'd3, 5'd31);
    reject(2'd3, 2'd0, 5'd0);

    expect_wr(1'b1, 8'h21, "R4");
    send(2'd0, 8'h21, 2'd0, 5'd0, r, e);
    wait_done();
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
    chk(fault == 1'b0, "R8", fault, 0);

    wr0 = n_wr;
    busy_forever = 1;
    send(2'd0, 8'h5A, 2'd0, 5'd0, r, e);
    repeat (200) @(negedge clk);
    chk(fault == 1'b1, "R8", fault, 1);
    chk(bus_req == 1'b0 && cmd_ready == 1'b0, "R8", {bus_req, cmd_ready}, 0);
    chk(n_wr == wr0, "R8", n_wr, wr0);
    busy_forever = 0;
    repeat (50) @(negedge clk);
    chk(fault == 1'b1 && bus_req == 1'b0, "R8", {fault, bus_req}, 2);
    chk(n_wr == wr0, "R8", n_wr, wr0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule